// File: doc/BRIEF.md
# Priority Ternary Match Classifier

The block is a small ternary lookup table for one key field of `KEY_W` bits. Each of its `ENTRIES` slots holds a stored value, a don't-care mask, a valid flag and a one-bit action that is either accept or deny. A search key is compared with every slot in parallel. The matching valid slot with the lowest index wins, and the block returns its index and action. When no valid slot matches, the block returns a miss with the action set to deny.

Because actions are resolved by first match, software can encode a numeric range from the outside. Deny slots are placed ahead to carve away the values outside the range, and one final all-don't-care accept slot catches everything that is left. Plain prefix encodings, in which every slot accepts, work as well. Software computes the slot contents; the block only stores and searches them.

Slots are loaded one at a time through a plain configuration port. Searches enter and results leave on valid/ready streams. A key is taken on any clock edge where `key_valid` and `key_ready` are both high. Its result is held in a single output register. That register may be refilled on the same edge that the sink takes the old result, so `key_ready` is low only while a result is waiting and `res_ready` is low. While `res_valid` is high and `res_ready` is low, the result stays frozen.

Top module: `tcl_classifier`

## Requirements
- R1: A slot matches a key when its valid flag is 1 and, for every bit position, the mask bit is 1 (don't-care) or the stored bit equals the key bit. A slot whose valid flag is 0 never matches.
- R2: When several slots match, `res_index` reports the lowest matching index and `res_hit` is 1.
- R3: `res_accept` equals the action bit of the winning slot (1 = accept, 0 = deny).
- R4: When no slot matches, `res_hit` is 0, `res_accept` is 0 (deny) and `res_index` is 0.
- R5: A key taken on clock edge k has its result on the outputs with `res_valid` high right after edge k. The search uses the table as it stood before any configuration write made on that same edge.
- R6: `key_ready` equals `!res_valid || res_ready`. While `res_valid` is 1 and `res_ready` is 0, `res_valid` and all result fields hold their values.
- R7: When `cfg_we` is 1 on an edge and `cfg_addr < ENTRIES`, the slot at that address takes `cfg_value`, `cfg_mask`, `cfg_accept` and `cfg_valid`, replacing its old contents. After reset every slot is invalid and `res_valid` is 0.
- R8: With deny slots for the values outside a range [lo,hi] ahead of one all-don't-care accept slot, exactly the keys in [lo,hi] return accept. Examples: [1,14] uses deny 0000, deny 1111, accept ****; [0,14] uses deny 1111, accept ****.
- R9: A prefix encoding of accept slots with no catch-all accepts exactly the keys it covers. Example: [2,4] uses 001* and 0100, and every other key misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one slot this edge |
| cfg_addr | input | IDX_W | Slot address |
| cfg_value | input | KEY_W | Stored value |
| cfg_mask | input | KEY_W | Don't-care mask, 1 = ignore bit |
| cfg_accept | input | 1 | Slot action, 1 = accept, 0 = deny |
| cfg_valid | input | 1 | Slot valid flag |
| key_valid | input | 1 | Search key offered |
| key_ready | output | 1 | Search key can be taken |
| key_data | input | KEY_W | Search key |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Sink takes result |
| res_hit | output | 1 | Some valid slot matched |
| res_index | output | IDX_W | Winning slot index, 0 on miss |
| res_accept | output | 1 | Winning action, 0 on miss |

## Verification
A wrong stored bit or mask bit flips the outcome only for the keys that reach that slot. For that reason every loaded encoding is swept over all keys, and each result is compared one cycle after its key is taken. A broken priority chain shows as a wrong `res_index` on the first key that matches two slots. A slip in the hold logic shows as changed fields during the first stalled cycle. A write that takes effect on the wrong edge shows on a search issued in the same cycle as that write.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  typedef enum logic {
    ACT_DENY   = 1'b0,
    ACT_ACCEPT = 1'b1
  } act_e;

  typedef struct packed {
    logic hit;
    logic accept;
  } verdict_t;
endpackage

// File: rtl/tcl_entry_store.sv
module tcl_entry_store #(
  parameter int KEY_W   = 4,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_addr,
  input  logic [KEY_W-1:0]                wr_value,
  input  logic [KEY_W-1:0]                wr_mask,
  input  logic                            wr_act,
  input  logic                            wr_valid,
  output logic [ENTRIES-1:0][KEY_W-1:0]   value_q,
  output logic [ENTRIES-1:0][KEY_W-1:0]   mask_q,
  output logic [ENTRIES-1:0]              act_q,
  output logic [ENTRIES-1:0]              vld_q
);
  logic addr_ok;
  assign addr_ok = (32'(wr_addr) < ENTRIES);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en && addr_ok && (32'(wr_addr) == e);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        value_q[e] <= '0;
        mask_q[e]  <= '0;
        act_q[e]   <= 1'b0;
        vld_q[e]   <= 1'b0;
      end else if (sel) begin
        value_q[e] <= wr_value;
        mask_q[e]  <= wr_mask;
        act_q[e]   <= wr_act;
        vld_q[e]   <= wr_valid;
      end
    end
  end

  // R7: a write lands in the addressed slot
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_ok) |=> (vld_q[$past(wr_addr)] == $past(wr_valid)) &&
                           (value_q[$past(wr_addr)] == $past(wr_value)) &&
                           (act_q[$past(wr_addr)] == $past(wr_act)));

  // R7: without a write the table holds
  a_r7_table_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q) && $stable(act_q));
endmodule

// File: rtl/tcl_match_array.sv
module tcl_match_array #(
  parameter int KEY_W   = 4,
  parameter int ENTRIES = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [KEY_W-1:0]                key,
  input  logic [ENTRIES-1:0][KEY_W-1:0]   value_q,
  input  logic [ENTRIES-1:0][KEY_W-1:0]   mask_q,
  input  logic [ENTRIES-1:0]              vld_q,
  output logic [ENTRIES-1:0]              match
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [KEY_W-1:0] bit_ok;
    assign bit_ok   = ~(value_q[e] ^ key) | mask_q[e];
    assign match[e] = vld_q[e] & (&bit_ok);
  end

  // R1: an invalid slot never contributes a match
  a_r1_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (match & ~vld_q) == '0);
endmodule

// File: rtl/tcl_prio_enc.sv
module tcl_prio_enc #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] req,
  output logic [ENTRIES-1:0] grant,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  logic [ENTRIES:0] seen;
  assign seen[0] = 1'b0;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_chain
    assign grant[e]  = req[e] & ~seen[e];
    assign seen[e+1] = seen[e] | req[e];
  end

  assign any = seen[ENTRIES];

  always_comb begin
    idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (grant[e]) idx = IDX_W'(e);
    end
  end

  // R2: at most one winner, and it is a requester
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

  // R2: any request yields exactly one winner
  a_r2_grant_present: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> ($countones(grant) == 1));
endmodule

// File: rtl/tcl_result_stage.sv
module tcl_result_stage #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic             act,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_hit,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_accept
);
  import tcl_pkg::*;

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_idx    <= '0;
      out_accept <= ACT_DENY;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_hit    <= hit;
      out_idx    <= hit ? idx : '0;
      out_accept <= hit ? act : ACT_DENY;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R6: a stalled result is frozen
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_hit) &&
                                  $stable(out_idx) && $stable(out_accept));

  // R4: a miss reports deny and index zero
  a_r4_miss_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_accept == ACT_DENY) && (out_idx == '0));

  // R5: a taken key yields a result next cycle
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
endmodule

// File: rtl/tcl_classifier.sv
module tcl_classifier #(
  parameter int KEY_W   = 4,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_addr,
  input  logic [KEY_W-1:0] cfg_value,
  input  logic [KEY_W-1:0] cfg_mask,
  input  logic             cfg_accept,
  input  logic             cfg_valid,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [KEY_W-1:0] key_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_index,
  output logic             res_accept
);
  logic [ENTRIES-1:0][KEY_W-1:0] value_q;
  logic [ENTRIES-1:0][KEY_W-1:0] mask_q;
  logic [ENTRIES-1:0]            act_q;
  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0]            match;
  logic [ENTRIES-1:0]            grant;
  logic [IDX_W-1:0]              win_idx;
  logic                          any_hit;
  logic                          win_act;

  tcl_entry_store #(.KEY_W(KEY_W), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_value(cfg_value),
    .wr_mask(cfg_mask), .wr_act(cfg_accept), .wr_valid(cfg_valid),
    .value_q(value_q), .mask_q(mask_q), .act_q(act_q), .vld_q(vld_q)
  );

  tcl_match_array #(.KEY_W(KEY_W), .ENTRIES(ENTRIES)) u_match (
    .clk(clk), .rst_n(rst_n), .key(key_data),
    .value_q(value_q), .mask_q(mask_q), .vld_q(vld_q), .match(match)
  );

  tcl_prio_enc #(.ENTRIES(ENTRIES)) u_prio (
    .clk(clk), .rst_n(rst_n), .req(match),
    .grant(grant), .idx(win_idx), .any(any_hit)
  );

  assign win_act = |(grant & act_q);

  tcl_result_stage #(.ENTRIES(ENTRIES)) u_res (
    .clk(clk), .rst_n(rst_n),
    .in_valid(key_valid), .in_ready(key_ready),
    .hit(any_hit), .idx(win_idx), .act(win_act),
    .out_valid(res_valid), .out_ready(res_ready),
    .out_hit(res_hit), .out_idx(res_index), .out_accept(res_accept)
  );

  // R3: the reported action is the winner's action
  a_r3_action_of_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready && any_hit) |=> res_accept == $past(act_q[win_idx]));
endmodule

// File: tb/sim_tcl_classifier.sv
module sim_tcl_classifier;
  localparam int KW = 4;
  localparam int NE = 16;
  localparam int IW = 4;
  localparam int NK = 1 << KW;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_accept = 0, cfg_valid = 0;
  logic [IW-1:0] cfg_addr = '0;
  logic [KW-1:0] cfg_value = '0, cfg_mask = '0, key_data = '0;
  logic key_valid = 0, key_ready, res_valid, res_ready = 1, res_hit, res_accept;
  logic [IW-1:0] res_index;

  always #5 clk = ~clk;

  tcl_classifier #(.KEY_W(KW), .ENTRIES(NE)) u0 (.*);

  int checks = 0, failures = 0, cycles = 0;
  int m_val[NE], m_msk[NE], m_act[NE], m_vld[NE];
  int q_hit[$], q_idx[$], q_acc[$], q_key[$], q_tag[$];
  int sw_tag = 0, sw_lo = 0, sw_hi = 0;
  bit stall_en = 0;
  logic pv = 0, pr = 1, ph = 0, pa = 0;
  logic [IW-1:0] pi = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void lookup(int k, output int h, output int ix, output int ac);
    h = 0; ix = 0; ac = 0;
    for (int e = 0; e < NE; e++) begin
      if (m_vld[e] != 0 && ((k ^ m_val[e]) & ~m_msk[e] & (NK-1)) == 0) begin
        h = 1; ix = e; ac = m_act[e];
        break;
      end
    end
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(key_ready == (!res_valid || res_ready), "R6", key_ready, !res_valid || res_ready);
      if (pv && !pr) begin
        chk(res_valid && res_hit == ph && res_index == pi && res_accept == pa,
            "R6", {res_hit, res_accept}, {ph, pa});
      end
      chk(res_valid == (q_hit.size() != 0), "R5", res_valid, q_hit.size() != 0);
      if (res_valid && res_ready && q_hit.size() != 0) begin
        int eh, ei, ea, ek, et;
        eh = q_hit.pop_front(); ei = q_idx.pop_front(); ea = q_acc.pop_front();
        ek = q_key.pop_front(); et = q_tag.pop_front();
        chk(res_hit == eh, "R1", res_hit, eh);
        chk(res_index == ei, eh ? "R2" : "R4", res_index, ei);
        chk(res_accept == ea, eh ? "R3" : "R4", res_accept, ea);
        if (et == 8) chk(res_accept == (ek >= sw_lo && ek <= sw_hi), "R8", res_accept, ek);
        if (et == 9) chk(res_accept == (ek >= sw_lo && ek <= sw_hi), "R9", res_accept, ek);
      end
      if (key_valid && key_ready) begin
        int h, ix, ac;
        lookup(int'(key_data), h, ix, ac);
        q_hit.push_back(h); q_idx.push_back(ix); q_acc.push_back(ac);
        q_key.push_back(int'(key_data)); q_tag.push_back(sw_tag);
      end
      if (cfg_we) begin
        m_val[cfg_addr] = cfg_value; m_msk[cfg_addr] = cfg_mask;
        m_act[cfg_addr] = cfg_accept; m_vld[cfg_addr] = cfg_valid;
      end
      pv = res_valid; pr = res_ready; ph = res_hit; pi = res_index; pa = res_accept;
      res_ready <= stall_en ? (cycles % 3 != 0) : 1'b1;
    end
  end

  task automatic wr(int a, int v, int m, int ac, int vl);
    cfg_we = 1; cfg_addr = IW'(a); cfg_value = KW'(v); cfg_mask = KW'(m);
    cfg_accept = ac[0]; cfg_valid = vl[0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_all();
    for (int e = 0; e < NE; e++) wr(e, 0, 0, 0, 0);
  endtask

  task automatic send(int k);
    key_data = KW'(k); key_valid = 1;
    while (!key_ready) @(negedge clk);
    @(negedge clk);
    key_valid = 0;
  endtask

  task automatic sweep(int tag, int lo, int hi);
    sw_tag = tag; sw_lo = lo; sw_hi = hi;
    for (int k = 0; k < NK; k++) send(k);
    while (q_hit.size() != 0) @(negedge clk);
    sw_tag = 0;
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin m_val[e] = 0; m_msk[e] = 0; m_act[e] = 0; m_vld[e] = 0; end
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(res_valid == 0, "R7", res_valid, 0);
    chk(key_ready == 1, "R6", key_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R4: empty table misses everywhere
    sweep(0, 0, 0);
    // R8: [1,14] from its exterior
    wr(0, 0, 0, 0, 1); wr(1, 15, 0, 0, 1); wr(2, 0, 15, 1, 1);
    sweep(8, 1, 14);
    // R8: extremal [0,14]
    clear_all();
    wr(0, 15, 0, 0, 1); wr(1, 0, 15, 1, 1);
    sweep(8, 0, 14);
    // R9: prefix encoding of [2,4]
    clear_all();
    wr(0, 2, 1, 1, 1); wr(1, 4, 0, 1, 1);
    sweep(9, 2, 4);
    // R1, R2: invalid slot 0 ignored; overlapping slots 5 and 9
    clear_all();
    wr(0, 0, 15, 0, 0); wr(5, 8, 7, 1, 1); wr(9, 0, 15, 0, 1); wr(12, 3, 0, 1, 1);
    sweep(0, 0, 0);
    // R7: overwrite slot 9 and rerun
    wr(9, 0, 15, 1, 1);
    sweep(9, 0, 15);
    // R6: back-pressure during a sweep
    stall_en = 1;
    sweep(9, 0, 15);
    stall_en = 0;
    // R5: write and search on the same edge see the old table
    @(negedge clk);
    key_data = 4'd3; key_valid = 1;
    cfg_we = 1; cfg_addr = 4'd5; cfg_value = 4'd3; cfg_mask = 4'd0; cfg_accept = 0; cfg_valid = 1;
    @(negedge clk);
    key_valid = 0; cfg_we = 0;
    send(3);
    repeat (4) @(negedge clk);
    chk(q_hit.size() == 0, "R5", q_hit.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule